// File: doc/BRIEF.md
# Loadable Binary Counter with Cascade Carry

This block is a small synchronous binary counter. It can be preset from a parallel data word, advanced by one on each rising clock edge while counting is enabled, or left to hold its value. An active-low clear acts at once, without waiting for a clock edge, and returns the count to zero.

When several decisions could apply, a fixed order picks one. Clear comes first, then the parallel load, then the increment, and otherwise the value holds. A combinational carry output marks the cycle in which an enabled increment will roll the count over from all ones to zero. Wiring this carry into the count enable of a second copy builds a wider counter in which both stages move on the same edge.

Top module: `ld_bin_counter`

## Requirements
- R1: While `clr_n` is low, `q` is 0 immediately, without a clock edge, whatever `load_en`, `cnt_en` and `din` are, and it stays 0 across clock edges.
- R2: With `clr_n` high and `load_en` = 1, `q` takes the value of `din` at the rising edge, whether `cnt_en` is 0 or 1.
- R3: With `clr_n` high, `load_en` = 0 and `cnt_en` = 1, `q` increases by one at the rising edge.
- R4: With `clr_n` high, `load_en` = 0 and `cnt_en` = 0, `q` keeps its value across the rising edge.
- R5: An increment from the all-ones value (1111 at the default width) gives 0000.
- R6: `carry_out` is 1 in exactly the cycles where `q` is all ones, `cnt_en` = 1 and `load_en` = 0. It is valid in that cycle, so a second stage with its `cnt_en` driven by `carry_out` increments at the same edge where the first stage wraps.
- R7: A `q` of all ones does not raise `carry_out` when `cnt_en` = 0 or when `load_en` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_en | input | 1 | Parallel preset request |
| cnt_en | input | 1 | Increment enable |
| din | input | WIDTH (4) | Preset value |
| q | output | WIDTH (4) | Current count |
| carry_out | output | 1 | Terminal-count carry for a higher stage |

## Verification
Load and increment can both be requested in the same cycle. The bench drives `load_en` and `cnt_en` high together, once while the count is mid-range and once while it sits at all ones. The check is that the loaded word wins, and that `carry_out` stays low and the higher cascaded stage does not move. Clear is also dropped while a load is pending, and the bench checks that `q` falls to zero before any edge and stays there.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2
  } ldc_op_e;

  // Next register value for a given operation.
  function automatic logic [31:0] ldc_next(input ldc_op_e op,
                                           input logic [31:0] cur,
                                           input logic [31:0] pre,
                                           input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    unique case (op)
      OP_LOAD: ldc_next = pre & mask;
      OP_INC:  ldc_next = (cur + 32'd1) & mask;
      default: ldc_next = cur & mask;
    endcase
  endfunction

  // True when every one of the low w bits is set.
  function automatic logic ldc_terminal(input logic [31:0] cur,
                                        input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    ldc_terminal = ((cur & mask) == mask);
  endfunction

endpackage

// File: rtl/ldc_ctrl.sv
module ldc_ctrl
  import ldc_pkg::*;
(
  input  logic    load_en,
  input  logic    cnt_en,
  output ldc_op_e op_sel
);
  // Load outranks count; neither means hold.
  always_comb begin
    if (load_en)     op_sel = OP_LOAD;
    else if (cnt_en) op_sel = OP_INC;
    else             op_sel = OP_HOLD;
  end
endmodule

// File: rtl/ldc_state.sv
module ldc_state
  import ldc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  ldc_op_e          op_sel,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  logic [31:0] nxt_wide;
  logic [31:0] cur_wide;
  logic [31:0] pre_wide;

  always_comb begin
    cur_wide = '0;
    pre_wide = '0;
    cur_wide[WIDTH-1:0] = q;
    pre_wide[WIDTH-1:0] = din;
    nxt_wide = ldc_next(op_sel, cur_wide, pre_wide, WIDTH);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= nxt_wide[WIDTH-1:0];
  end
endmodule

// File: rtl/ldc_carry.sv
module ldc_carry
  import ldc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  ldc_op_e          op_sel,
  output logic             term_hit,
  output logic             carry_out
);
  logic [31:0] cur_wide;

  always_comb begin
    cur_wide = '0;
    cur_wide[WIDTH-1:0] = q;
    term_hit  = ldc_terminal(cur_wide, WIDTH);
    carry_out = term_hit && (op_sel == OP_INC);
  end
endmodule

// File: rtl/ld_bin_counter.sv
module ld_bin_counter
  import ldc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_en,
  input  logic             cnt_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  ldc_op_e op_sel;
  logic    term_hit;

  ldc_ctrl u_ctrl (
    .load_en (load_en),
    .cnt_en  (cnt_en),
    .op_sel  (op_sel)
  );

  ldc_state #(.WIDTH(WIDTH)) u_state (
    .clk    (clk),
    .clr_n  (clr_n),
    .op_sel (op_sel),
    .din    (din),
    .q      (q)
  );

  ldc_carry #(.WIDTH(WIDTH)) u_carry (
    .q         (q),
    .op_sel    (op_sel),
    .term_hit  (term_hit),
    .carry_out (carry_out)
  );
endmodule

// File: rtl/ldc_chk.sv
module ldc_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_en,
  input logic             cnt_en,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry_out
);
  localparam logic [WIDTH-1:0] ALL1 = '1;

  // R1: clear holds the count at zero
  always @(negedge clk) begin
    if (!clr_n) a_r1_clear_zero: assert (q == '0);
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!clr_n)
    load_en |=> q == $past(din));

  a_r3_inc: assert property (@(posedge clk) disable iff (!clr_n)
    (!load_en && cnt_en) |=> q == WIDTH'($past(q) + 1'b1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (!load_en && !cnt_en) |=> $stable(q));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!clr_n)
    (q == ALL1 && cnt_en && !load_en) |=> q == '0);

  a_r6_carry_next_zero: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |=> q == '0);

  a_r6_carry_at_top: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> q == ALL1);

  a_r7_no_carry_on_load: assert property (@(posedge clk) disable iff (!clr_n)
    (load_en || !cnt_en) |-> !carry_out);
endmodule

bind ld_bin_counter ldc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_en   (load_en),
  .cnt_en    (cnt_en),
  .din       (din),
  .q         (q),
  .carry_out (carry_out)
);

// File: tb/sim_ld_bin_counter.sv
`timescale 1ns/100ps
module sim_ld_bin_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic ld = 1'b0;
  logic ce = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] dh = '0;
  logic [W-1:0] q, qh;
  logic co, coh;

  always #2 clk = ~clk;

  ld_bin_counter #(.WIDTH(W)) u0 (
    .clk(clk), .clr_n(clr_n), .load_en(ld), .cnt_en(ce),
    .din(d), .q(q), .carry_out(co));

  ld_bin_counter #(.WIDTH(W)) u1 (
    .clk(clk), .clr_n(clr_n), .load_en(ld), .cnt_en(co),
    .din(dh), .q(qh), .carry_out(coh));

  typedef struct {
    logic [W-1:0] lo;
    logic [W-1:0] hi;
    string        tag;
  } exp_t;

  exp_t sb[$];
  int runs = 0;
  int fails = 0;
  logic [W-1:0] m_lo = '0;
  logic [W-1:0] m_hi = '0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, check carry now, queue next state.
  task automatic step(input string tag, input logic l, input logic c,
                      input logic [W-1:0] dv, input logic [W-1:0] dhv);
    logic ecar;
    @(negedge clk);
    ld = l; ce = c; d = dv; dh = dhv;
    #1;
    ecar = (m_lo == '1) && c && !l;
    chk({tag, " carry"}, {7'd0, co}, {7'd0, ecar});
    if (l) begin
      m_lo = dv; m_hi = dhv;
    end else if (c) begin
      if (ecar) m_hi = m_hi + 1'b1;
      m_lo = m_lo + 1'b1;
    end
    sb.push_back('{m_lo, m_hi, tag});
  endtask

  // Monitor: compare registered outputs after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " q"}, {4'd0, q}, {4'd0, e.lo});
        chk({e.tag, " hi"}, {4'd0, qh}, {4'd0, e.hi});
      end
    end
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    #200000;
    runs++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    #1;
    chk("R1 reset q", {4'd0, q}, 8'd0);
    chk("R1 reset carry", {7'd0, co}, 8'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    clr_n = 1'b1;

    step("R2 load 5", 1'b1, 1'b0, 4'h5, 4'h2);
    step("R4 hold", 1'b0, 1'b0, 4'hA, 4'hA);
    step("R3 inc a", 1'b0, 1'b1, 4'h0, 4'h0);
    step("R3 inc b", 1'b0, 1'b1, 4'h0, 4'h0);
    step("R2 load beats count", 1'b1, 1'b1, 4'hE, 4'h7);
    step("R3 inc to top", 1'b0, 1'b1, 4'h0, 4'h0);
    step("R5 R6 wrap cascade", 1'b0, 1'b1, 4'h0, 4'h0);
    step("R2 load top", 1'b1, 1'b0, 4'hF, 4'h1);
    step("R7 top held", 1'b0, 1'b0, 4'h3, 4'h3);
    step("R7 top load+count", 1'b1, 1'b1, 4'hF, 4'h1);
    step("R6 top count", 1'b0, 1'b1, 4'h0, 4'h0);
    step("R3 inc after wrap", 1'b0, 1'b1, 4'h0, 4'h0);

    // R1: clear in mid-cycle with a load pending
    @(posedge clk);
    #1;
    ld = 1'b1; ce = 1'b1; d = 4'h9; dh = 4'h9;
    clr_n = 1'b0;
    #0.5;
    chk("R1 async q", {4'd0, q}, 8'd0);
    chk("R1 async hi", {4'd0, qh}, 8'd0);
    @(posedge clk);
    #1;
    chk("R1 held over edge", {4'd0, q}, 8'd0);
    chk("R1 carry low", {7'd0, co}, 8'd0);
    @(negedge clk);
    ld = 1'b0; ce = 1'b0;
    clr_n = 1'b1;
    m_lo = '0; m_hi = '0;

    step("R2 preload cascade", 1'b1, 1'b0, 4'hF, 4'h3);
    step("R6 cascade step", 1'b0, 1'b1, 4'h0, 4'h0);
    step("R4 hold end", 1'b0, 1'b0, 4'h5, 4'h5);

    repeat (3) @(posedge clk);
    #1;
    summary();
  end
endmodule